// File: doc/BRIEF.md
# I2C EEPROM Read Sequencer

This block is an I2C bus master that performs read transactions against a serial EEPROM with a 13-bit word address. A client puts a request on a valid/ready port: an operation code, a word address, a byte count and a three-bit chip select. The block then runs the whole bus sequence. It generates SCL from a fixed divider and drives both lines as open-drain pull-down enables. Each received byte comes out on a valid/ready data stream. When the stop condition has finished, a one-cycle `done` pulse marks the end of the request. An accompanying `nack_err` reports that the memory refused a control or address byte.

For a random or sequential read the block first sends a control byte with the write direction, then the two address bytes. It follows these with a repeated start and a control byte with the read direction. A current-address read skips the write phase and reads at wherever the memory's own pointer stands. During a burst the master acknowledges every byte except the last. The last byte gets a no-acknowledge and then a stop. While the client withholds `rd_ready`, SCL is held low, so the bus pauses with no loss of data.

The sequencer uses these states:
- `S_IDLE`: lines released.
- `S_START1` / `S_START2`: start setup and SDA fall.
- `S_RS0`: SCL low ahead of a repeated start.
- `S_TX_LO` / `S_TX_HI`: a transmitted bit.
- `S_TACK_LO` / `S_TACK_HI`: the slave acknowledge slot.
- `S_RX_LO` / `S_RX_HI`: a received bit.
- `S_HAND`: byte offered to the client.
- `S_RACK_LO` / `S_RACK_HI`: the master acknowledge slot.
- `S_STOP1..3`: stop.

The transitions are:
- accept: IDLE to START1.
- start: START1 to START2 to TX_LO.
- bit loop: TX_HI to TX_LO, and RX_HI to RX_LO.
- byte end: TX_HI to TACK_LO, and RX_HI to HAND.
- slave ack, by phase:
  - after the write control byte or the high address byte: TACK_HI to TX_LO.
  - after the low address byte: TACK_HI to RS0 to START1.
  - after the read control byte: TACK_HI to RX_LO.
- refusal: TACK_HI to STOP1.
- hand-off: HAND to RACK_LO once accepted.
- burst continue: RACK_HI to RX_LO.
- burst end: RACK_HI to STOP1.
- finish: STOP3 to IDLE.

Every timed state lasts `CLK_DIV` system clocks.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the stop condition has completed, and high otherwise.
- R2: Every control byte is sent MSB first as binary 1010, then `req_chip[2:0]`, then a direction bit (0 = write, 1 = read).
- R3: With `req_op` = 2'b01 (random), the block sends start, control byte with write direction, address high byte, address low byte, repeated start, control byte with read direction, and then reads exactly one byte. The high byte carries zeros above the address bits.
- R4: With `req_op` = 2'b00 (current-address), the block sends one start, a read-direction control byte only, reads one byte, answers it with no-acknowledge and sends a stop.
- R5: With `req_op` = 2'b10 (sequential), the block reads `req_len` bytes from consecutive addresses, with `req_len` = 0 taken as 1. It acknowledges all but the last byte and gives the last one a no-acknowledge.
- R6: Each received byte is offered on `rd_data` with `rd_valid` high and stays unchanged until `rd_ready` is high. During that wait SCL is driven low.
- R7: If any control or address byte is not acknowledged (SDA high in the acknowledge slot), the block sends a stop, returns to idle and delivers no data byte.
- R8: `done` is a single-cycle pulse in the cycle the block is idle again after a stop. `nack_err` is high only together with `done`, and only for a refused transfer.
- R9: SCL runs with a period of 2 × `CLK_DIV` system clocks while bits are being transferred.
- R10: Outputs `scl_drive_low` and `sda_drive_low` are pull-down enables (1 = pull line low). Both are 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 00 current-address, 01 random, 10 sequential |
| req_addr | input | ADDR_W | Word address for random and sequential reads |
| req_len | input | LEN_W | Byte count for sequential reads (0 means 1) |
| req_chip | input | 3 | Chip-select bits placed in the control byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Client takes the byte |
| rd_data | output | 8 | Received byte |
| done | output | 1 | One-cycle pulse at the end of a request |
| nack_err | output | 1 | With `done`: a control or address byte was refused |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The properties assume that `sda_in` is the wired-AND of the block's own pull-down and a well-behaved slave. They also assume that the slave changes SDA only while SCL is low and never stretches the clock. The bench's memory model meets this: it updates its pull-down only after it sees a falling SCL, and it reads bits only on a rising SCL. The properties also assume that the client never withdraws a byte handshake it has offered. The bench's stall pattern only raises or lowers `rd_ready`, and it counts a byte only when valid and ready meet at a clock edge.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    typedef enum logic [1:0] {
        OP_CUR  = 2'b00,
        OP_RAND = 2'b01,
        OP_SEQ  = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RS0, S_START1, S_START2,
        S_TX_LO, S_TX_HI, S_TACK_LO, S_TACK_HI,
        S_RX_LO, S_RX_HI, S_HAND, S_RACK_LO,
        S_RACK_HI, S_STOP1, S_STOP2, S_STOP3
    } st_e;

    typedef enum logic [1:0] {
        PH_CTRLW, PH_ADRH, PH_ADRL, PH_CTRLR
    } phase_e;

    localparam logic [3:0] CTRL_TAG = 4'b1010;

endpackage

// File: rtl/i2c_rd_tick.sv
module i2c_rd_tick #(
    parameter int CLK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!en || tick) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_rd_shift.sv
module i2c_rd_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       shift_tx,
    input  logic       shift_rx,
    input  logic       rx_bit,
    output logic       tx_msb,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_q, rx_q;

    assign tx_msb  = tx_q[7];
    assign rx_byte = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= 8'hFF;
            rx_q <= 8'h00;
        end else begin
            if (load)          tx_q <= load_val;
            else if (shift_tx) tx_q <= {tx_q[6:0], 1'b1};
            if (shift_rx)      rx_q <= {rx_q[6:0], rx_bit};
        end
    end
endmodule

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader
    import i2c_rd_pkg::*;
#(
    parameter int CLK_DIV = 125,
    parameter int ADDR_W  = 13,
    parameter int LEN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [2:0]        req_chip,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic              nack_err,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              sda_in
);
    localparam logic [2:0] LAST_BIT = 3'd7;

    st_e              st_q, st_d;
    phase_e           ph_q, ph_d;
    logic [2:0]       bit_q, bit_d;
    logic [LEN_W-1:0] left_q, left_d;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]       chip_q;
    logic             err_q, err_d;
    logic             done_q, nerr_q, done_d;
    logic             accept;

    logic       tick, tick_en;
    logic       sh_load, sh_tx, sh_rx, tx_msb;
    logic [7:0] sh_val, rx_byte;
    logic [15:0] addr_ext;

    op_e op_in;
    assign op_in    = op_e'(req_op);
    assign accept   = (st_q == S_IDLE) && req_valid;
    assign tick_en  = (st_q != S_IDLE) && (st_q != S_HAND);
    assign addr_ext = 16'(addr_q);

    i2c_rd_tick #(.CLK_DIV(CLK_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .en(tick_en), .tick(tick)
    );

    i2c_rd_shift shift_i (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
        .shift_tx(sh_tx), .shift_rx(sh_rx), .rx_bit(sda_in),
        .tx_msb(tx_msb), .rx_byte(rx_byte)
    );

    // next-state and datapath strobes
    always_comb begin
        st_d    = st_q;
        ph_d    = ph_q;
        bit_d   = bit_q;
        left_d  = left_q;
        err_d   = err_q;
        done_d  = 1'b0;
        sh_load = 1'b0;
        sh_val  = 8'hFF;
        sh_tx   = 1'b0;
        sh_rx   = 1'b0;
        unique case (st_q)
            S_IDLE: if (accept) begin
                st_d    = S_START1;
                ph_d    = (op_in == OP_CUR) ? PH_CTRLR : PH_CTRLW;
                sh_load = 1'b1;
                sh_val  = {CTRL_TAG, req_chip, op_in == OP_CUR};
                left_d  = (op_in == OP_SEQ && req_len != '0) ?
                          LEN_W'(req_len - 1'b1) : '0;
                err_d   = 1'b0;
                bit_d   = '0;
            end
            S_RS0:     if (tick) st_d = S_START1;
            S_START1:  if (tick) st_d = S_START2;
            S_START2:  if (tick) begin st_d = S_TX_LO; bit_d = '0; end
            S_TX_LO:   if (tick) st_d = S_TX_HI;
            S_TX_HI:   if (tick) begin
                if (bit_q == LAST_BIT) st_d = S_TACK_LO;
                else begin
                    sh_tx = 1'b1;
                    bit_d = bit_q + 3'd1;
                    st_d  = S_TX_LO;
                end
            end
            S_TACK_LO: if (tick) st_d = S_TACK_HI;
            S_TACK_HI: if (tick) begin
                bit_d = '0;
                if (sda_in) begin
                    err_d = 1'b1;
                    st_d  = S_STOP1;
                end else begin
                    unique case (ph_q)
                        PH_CTRLW: begin
                            ph_d = PH_ADRH; sh_load = 1'b1;
                            sh_val = addr_ext[15:8]; st_d = S_TX_LO;
                        end
                        PH_ADRH: begin
                            ph_d = PH_ADRL; sh_load = 1'b1;
                            sh_val = addr_ext[7:0]; st_d = S_TX_LO;
                        end
                        PH_ADRL: begin
                            ph_d = PH_CTRLR; sh_load = 1'b1;
                            sh_val = {CTRL_TAG, chip_q, 1'b1}; st_d = S_RS0;
                        end
                        PH_CTRLR: st_d = S_RX_LO;
                    endcase
                end
            end
            S_RX_LO:   if (tick) st_d = S_RX_HI;
            S_RX_HI:   if (tick) begin
                sh_rx = 1'b1;
                if (bit_q == LAST_BIT) st_d = S_HAND;
                else begin bit_d = bit_q + 3'd1; st_d = S_RX_LO; end
            end
            S_HAND:    if (rd_ready) st_d = S_RACK_LO;
            S_RACK_LO: if (tick) st_d = S_RACK_HI;
            S_RACK_HI: if (tick) begin
                if (left_q == '0) st_d = S_STOP1;
                else begin
                    left_d = left_q - 1'b1;
                    bit_d  = '0;
                    st_d   = S_RX_LO;
                end
            end
            S_STOP1:   if (tick) st_d = S_STOP2;
            S_STOP2:   if (tick) st_d = S_STOP3;
            S_STOP3:   if (tick) begin st_d = S_IDLE; done_d = 1'b1; end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            ph_q   <= PH_CTRLW;
            bit_q  <= '0;
            left_q <= '0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            nerr_q <= 1'b0;
            addr_q <= '0;
            chip_q <= '0;
        end else begin
            st_q   <= st_d;
            ph_q   <= ph_d;
            bit_q  <= bit_d;
            left_q <= left_d;
            err_q  <= err_d;
            done_q <= done_d;
            nerr_q <= done_d && err_q;
            if (accept) begin
                addr_q <= req_addr;
                chip_q <= req_chip;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        unique case (st_q)
            S_RS0, S_TACK_LO, S_RX_LO, S_HAND: scl_drive_low = 1'b1;
            S_START2, S_STOP2, S_STOP3:        sda_drive_low = (st_q != S_STOP3);
            S_TX_LO: begin scl_drive_low = 1'b1; sda_drive_low = !tx_msb; end
            S_TX_HI: sda_drive_low = !tx_msb;
            S_RACK_LO: begin scl_drive_low = 1'b1; sda_drive_low = (left_q != '0); end
            S_RACK_HI: sda_drive_low = (left_q != '0);
            S_STOP1: begin scl_drive_low = 1'b1; sda_drive_low = 1'b1; end
            default: ;
        endcase
    end

    assign req_ready = (st_q == S_IDLE);
    assign rd_valid  = (st_q == S_HAND);
    assign rd_data   = rx_byte;
    assign done      = done_q;
    assign nack_err  = nerr_q;
endmodule

// File: rtl/i2c_rd_checks.sv
module i2c_rd_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       done,
    input logic       nack_err,
    input logic       scl_drive_low,
    input logic       sda_drive_low
);
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    a_r6_scl_held: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> scl_drive_low);

    a_r6_idle_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rd_valid);

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        nack_err |-> done);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !scl_drive_low && !sda_drive_low);
endmodule

bind i2c_eeprom_reader i2c_rd_checks chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .nack_err(nack_err),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
);

// File: tb/i2c_eeprom_reader_tb.sv
module i2c_eeprom_reader_tb_top;
    localparam int DIV = 4;
    localparam logic [2:0] SLV_CHIP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [2:0]  req_chip = '0;
    logic        rd_ready = 1'b0;
    logic        req_ready, rd_valid, done, nack_err;
    logic        scl_drive_low, sda_drive_low;
    logic [7:0]  rd_data;
    logic        s_drv = 1'b0;
    logic        sda_line, scl_line;

    assign sda_line = !(sda_drive_low || s_drv);
    assign scl_line = !scl_drive_low;

    i2c_eeprom_reader #(.CLK_DIV(DIV), .ADDR_W(13), .LEN_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_chip(req_chip),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .nack_err(nack_err),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .sda_in(sda_line)
    );

    function automatic logic [7:0] mem_at(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    // ---------------- memory slave model ----------------
    int ss = 0, bc = 0, byteno = 0;
    logic [7:0] sh = '0, txb = '0, ahi = '0;
    logic rw = 1'b0, ok = 1'b0;
    logic [12:0] ptr = '0;
    int n_start = 0, n_stop = 0, n_mack = 0, n_mnack = 0, n_ctrl = 0;
    logic [7:0] ctrl_log [0:63];
    logic p_scl = 1'b1, p_sda = 1'b1;
    int cyc = 0, last_rise = 0, per_min = 1000000, per_max = 0;
    logic nack_lo = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            ss = 0; s_drv = 1'b0;
        end else if (scl_line && p_scl && p_sda && !sda_line) begin
            n_start = n_start + 1; ss = 1; bc = 0; byteno = 0; s_drv = 1'b0;
        end else if (scl_line && p_scl && !p_sda && sda_line) begin
            n_stop = n_stop + 1; ss = 0; s_drv = 1'b0;
        end else if (scl_line && !p_scl) begin
            if (ss == 1 && bc >= 1) begin
                if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                if (cyc - last_rise > per_max) per_max = cyc - last_rise;
            end
            last_rise = cyc;
            case (ss)
                1: begin
                    sh = {sh[6:0], sda_line}; bc = bc + 1;
                    if (bc == 8) begin
                        if (byteno == 0) begin
                            ok = (sh[7:1] == {4'b1010, SLV_CHIP}); rw = sh[0];
                            ctrl_log[n_ctrl % 64] = sh; n_ctrl = n_ctrl + 1;
                        end else if (byteno == 1) begin
                            ahi = sh; ok = 1'b1;
                        end else begin
                            ok = !nack_lo;
                            if (ok) ptr = {ahi[4:0], sh};
                        end
                        byteno = byteno + 1; ss = 2;
                    end
                end
                4: begin
                    bc = bc + 1;
                    if (bc == 8) begin ptr = ptr + 13'd1; ss = 5; end
                end
                6: begin
                    if (!sda_line) begin n_mack = n_mack + 1; ss = 7; end
                    else begin n_mnack = n_mnack + 1; ss = 0; end
                end
                default: ;
            endcase
        end else if (!scl_line && p_scl) begin
            case (ss)
                2: begin if (ok) begin s_drv = 1'b1; ss = 3; end else ss = 0; end
                3: begin
                    s_drv = 1'b0; bc = 0;
                    if (rw) begin txb = mem_at(ptr); s_drv = !txb[7]; ss = 4; end
                    else ss = 1;
                end
                4: s_drv = !txb[7 - bc];
                5: begin s_drv = 1'b0; ss = 6; end
                7: begin txb = mem_at(ptr); bc = 0; s_drv = !txb[7]; ss = 4; end
                default: ;
            endcase
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    // ---------------- bookkeeping ----------------
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit good, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!good) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [7:0] got [0:15];
    int ngot, viol, sclbad, b_start, b_stop, b_mack, b_mnack, b_ctrl;
    bit got_err, timed_out, done_after;

    task automatic run_req(input logic [1:0] op, input logic [12:0] a,
                           input logic [7:0] len, input logic [2:0] chip, input bit stall);
        int guard;
        int k;
        b_start = n_start; b_stop = n_stop; b_mack = n_mack;
        b_mnack = n_mnack; b_ctrl = n_ctrl;
        ngot = 0; viol = 0; sclbad = 0; got_err = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = len; req_chip = chip;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0; k = 0;
        while (guard < 20000) begin
            if (done) begin got_err = nack_err; break; end
            if (req_ready) viol = viol + 1;
            k = k + 1;
            rd_ready = stall ? (k % 4 == 0) : 1'b1;
            if (rd_valid && scl_line) sclbad = sclbad + 1;
            if (rd_valid && rd_ready && ngot < 16) begin got[ngot] = rd_data; ngot = ngot + 1; end
            @(negedge clk);
            guard = guard + 1;
        end
        timed_out = (guard >= 20000);
        rd_ready = 1'b0;
        @(negedge clk);
        done_after = done;
    endtask

    task automatic common_end(input string req);
        chk(!timed_out, req, "request completed", int'(timed_out), 0);
        chk(viol == 0, "R1", "ready low while busy", viol, 0);
        chk(!done_after, "R8", "done single cycle", int'(done_after), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(!scl_drive_low && !sda_drive_low, "R10", "lines released at reset",
            int'({scl_drive_low, sda_drive_low}), 0);
        chk(!rd_valid && !done && !nack_err, "R8", "no output at reset",
            int'({rd_valid, done, nack_err}), 0);
    endtask

    task automatic t_random;
        run_req(2'b01, 13'h1ABC, 8'd5, SLV_CHIP, 1'b0);
        common_end("R3");
        chk(ngot == 1, "R3", "random byte count", ngot, 1);
        chk(got[0] == mem_at(13'h1ABC), "R3", "random data", got[0], mem_at(13'h1ABC));
        chk(n_start - b_start == 2, "R3", "start plus repeated start", n_start - b_start, 2);
        chk(ctrl_log[b_ctrl % 64] == 8'hAA, "R2", "write control byte", ctrl_log[b_ctrl % 64], 8'hAA);
        chk(ctrl_log[(b_ctrl + 1) % 64] == 8'hAB, "R2", "read control byte",
            ctrl_log[(b_ctrl + 1) % 64], 8'hAB);
        chk(ahi == 8'h1A, "R3", "high address byte upper zeros", ahi, 8'h1A);
        chk(n_mnack - b_mnack == 1 && n_mack == b_mack, "R3", "single byte nacked",
            n_mnack - b_mnack, 1);
        chk(!got_err, "R8", "no error on good read", int'(got_err), 0);
    endtask

    task automatic t_current;
        run_req(2'b00, 13'h0000, 8'd0, SLV_CHIP, 1'b0);
        common_end("R4");
        chk(ngot == 1 && got[0] == mem_at(13'h1ABD), "R4", "current-address data",
            got[0], mem_at(13'h1ABD));
        chk(n_start - b_start == 1, "R4", "single start", n_start - b_start, 1);
        chk(n_ctrl - b_ctrl == 1 && ctrl_log[b_ctrl % 64] == 8'hAB, "R4", "only read control byte",
            ctrl_log[b_ctrl % 64], 8'hAB);
        chk(n_stop - b_stop == 1 && n_mnack - b_mnack == 1, "R4", "nack then stop",
            n_stop - b_stop, 1);
    endtask

    task automatic t_seq_stall;
        run_req(2'b10, 13'h1FFE, 8'd3, SLV_CHIP, 1'b1);
        common_end("R5");
        chk(ngot == 3, "R5", "burst length", ngot, 3);
        chk(got[0] == mem_at(13'h1FFE), "R5", "burst byte 0", got[0], mem_at(13'h1FFE));
        chk(got[1] == mem_at(13'h1FFF), "R5", "burst byte 1", got[1], mem_at(13'h1FFF));
        chk(got[2] == mem_at(13'h0000), "R5", "burst byte 2", got[2], mem_at(13'h0000));
        chk(n_mack - b_mack == 2, "R5", "acks inside burst", n_mack - b_mack, 2);
        chk(n_mnack - b_mnack == 1, "R5", "final nack", n_mnack - b_mnack, 1);
        chk(sclbad == 0, "R6", "SCL held low while byte waits", sclbad, 0);
    endtask

    task automatic t_seq_zero;
        run_req(2'b10, 13'h0040, 8'd0, SLV_CHIP, 1'b0);
        common_end("R5");
        chk(ngot == 1 && got[0] == mem_at(13'h0040), "R5", "zero length reads one byte",
            ngot, 1);
        chk(n_mack == b_mack, "R5", "no ack for single byte", n_mack - b_mack, 0);
    endtask

    task automatic t_bad_chip;
        run_req(2'b01, 13'h0123, 8'd1, 3'b011, 1'b0);
        common_end("R7");
        chk(got_err, "R7", "error on refused control byte", int'(got_err), 1);
        chk(ngot == 0, "R7", "no data after refusal", ngot, 0);
        chk(n_stop - b_stop == 1 && n_start - b_start == 1, "R7", "stop after refusal",
            n_stop - b_stop, 1);
        chk(ctrl_log[b_ctrl % 64] == 8'hA6, "R2", "chip bits in control byte",
            ctrl_log[b_ctrl % 64], 8'hA6);
    endtask

    task automatic t_bad_addr;
        nack_lo = 1'b1;
        run_req(2'b01, 13'h0005, 8'd1, SLV_CHIP, 1'b0);
        nack_lo = 1'b0;
        common_end("R7");
        chk(got_err, "R8", "error flag on refused address", int'(got_err), 1);
        chk(ngot == 0 && n_start - b_start == 1, "R7", "no repeated start after refusal",
            n_start - b_start, 1);
    endtask

    task automatic t_period;
        chk(per_min == 2 * DIV && per_max == 2 * DIV, "R9", "SCL period",
            per_max, 2 * DIV);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_random();
        t_current();
        t_seq_stall();
        t_seq_zero();
        t_bad_chip();
        t_bad_addr();
        t_period();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule